// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block derives the I2C serial clock from the peripheral clock. The low and high halves of each SCL period are timed separately, so the duty cycle can be set as well as the rate. A single 32-bit divider word carries both phase counts. Each count is worth eight peripheral clocks per unit, plus one unit, so a field value of N gives a phase of 8 × (N + 1) cycles.

The generator drives SCL only by pulling it low. It releases the line for the high phase, and it starts timing that phase only once the line is seen high, so a target that holds SCL low stretches the period. Four one-cycle strobes mark the start and the middle of each phase. The bit-level engine uses the mid-low strobe to change SDA and the mid-high strobe to sample it. A divider word written in the middle of a period takes effect at the start of the next low phase. Clearing the enable releases the line and parks the generator.

Top module: `scl_phase_gen`

## Requirements
- R1: While reset is asserted, and from the cycle after `enable` is sampled low, `scl_oe` is 0 and all four strobes are 0.
- R2: Each low phase (`scl_oe` = 1) lasts exactly 8 × (L + 1) clock cycles, where L is `div_cfg[15:0]`. The state of `scl_in` has no effect on it.
- R3: With no clock stretching, each high phase (`scl_oe` = 0 while enabled) lasts exactly 8 × (H + 1) clock cycles, where H is `div_cfg[31:16]`.
- R4: `low_start_stb` is 1 for exactly the first cycle of each low phase, and `high_start_stb` for exactly the first cycle of each high phase. At most one strobe is active in any cycle.
- R5: `mid_low_stb` pulses once per low phase, 4 × (L + 1) cycles after the first low cycle, while `scl_oe` is 1.
- R6: With no stretching, `mid_high_stb` pulses once per high phase, 4 × (H + 1) cycles after the first high cycle, while `scl_oe` is 0.
- R7: If `scl_in` is held low after release, the high phase waits. Once the line rises, the phase ends after 8 × (H + 1) clock edges, and `mid_high_stb` still pulses exactly once.
- R8: A `div_cfg` value changed after a low phase has begun does not affect that period's low or high phase. It is used from the next low phase on.
- R9: The cycle after `enable` is first sampled high, a new low phase begins: `scl_oe` = 1 and `low_start_stb` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; 0 releases SCL and parks all counters |
| div_cfg | input | 32 | High-phase count in [31:16], low-phase count in [15:0] |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | 1 pulls SCL low |
| low_start_stb | output | 1 | First cycle of a low phase |
| mid_low_stb | output | 1 | Middle of the low phase (SDA change point) |
| high_start_stb | output | 1 | First cycle of a high phase |
| mid_high_stb | output | 1 | Middle of the high phase (SDA sample point) |

## Verification
The bench uses the default parameters: 16-bit phase fields, eight clocks per unit and a two-stage line synchronizer. The two-stage synchronizer brings into reach the case where the counter must stall on a stretched line and make up for the synchronizer delay exactly. Divider words run from both fields at zero up to a 255-count low phase, so odd and strongly asymmetric duty cycles are measured cycle by cycle. The largest 16-bit counts are too long for the run and are covered only by the shared width arithmetic.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/scl_div_hold.sv
module scl_div_hold #(
  parameter int FW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [2*FW-1:0] div_in,
  output logic [FW-1:0]   lo_cnt,
  output logic [FW-1:0]   hi_cnt
);
  logic [2*FW-1:0] hold_q;
  logic [2*FW-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = div_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign lo_cnt = hold_q[FW-1:0];
  assign hi_cnt = hold_q[2*FW-1:FW];
endmodule

// File: rtl/scl_phase_engine.sv
module scl_phase_engine
  import scl_gen_pkg::*;
#(
  parameter int FW          = 16,
  parameter int UNIT_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line_hi,
  input  logic [FW-1:0] lo_cnt,
  input  logic [FW-1:0] hi_cnt,
  output logic          load,
  output logic          drive_low,
  output logic          low_start,
  output logic          mid_low,
  output logic          high_start,
  output logic          mid_high
);
  localparam int CW = FW + UNIT_LOG2;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_lo_v, last_hi_v, mid_lo_v, mid_hi_v;
  logic          at_last_lo, at_last_hi, hold;

  assign last_lo_v = {lo_cnt, {UNIT_LOG2{1'b1}}};
  assign last_hi_v = {hi_cnt, {UNIT_LOG2{1'b1}}};
  assign mid_lo_v  = CW'({1'b0, lo_cnt} + {{FW{1'b0}}, 1'b1}) << (UNIT_LOG2 - 1);
  assign mid_hi_v  = CW'({1'b0, hi_cnt} + {{FW{1'b0}}, 1'b1}) << (UNIT_LOG2 - 1);

  assign at_last_lo = (cnt_q == last_lo_v);
  assign at_last_hi = (cnt_q == last_hi_v);
  // stall point: the synchronizer delay is already counted, wait for the line
  assign hold = (ph_q == PH_HIGH) && (cnt_q == CW'(SYNC_STAGES)) && !line_hi;

  assign load = en && ((ph_q == PH_IDLE) ||
                       ((ph_q == PH_HIGH) && !hold && at_last_hi));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_LOW;
          cnt_d = '0;
        end
        PH_LOW: begin
          if (at_last_lo) begin
            ph_d  = PH_HIGH;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (!hold) begin
            if (at_last_hi) begin
              ph_d  = PH_LOW;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign drive_low  = (ph_q == PH_LOW);
  assign low_start  = (ph_q == PH_LOW)  && (cnt_q == '0);
  assign mid_low    = (ph_q == PH_LOW)  && (cnt_q == mid_lo_v);
  assign high_start = (ph_q == PH_HIGH) && (cnt_q == '0);
  assign mid_high   = (ph_q == PH_HIGH) && (cnt_q == mid_hi_v) && !hold;
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int FIELD_W     = 16,
  parameter int UNIT_LOG2   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [2*FIELD_W-1:0] div_cfg,
  input  logic                 scl_in,
  output logic                 scl_oe,
  output logic                 low_start_stb,
  output logic                 mid_low_stb,
  output logic                 high_start_stb,
  output logic                 mid_high_stb
);
  logic                line_hi;
  logic                load;
  logic [FIELD_W-1:0]  lo_cnt, hi_cnt;

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (line_hi)
  );

  scl_div_hold #(.FW(FIELD_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .div_in (div_cfg),
    .lo_cnt (lo_cnt),
    .hi_cnt (hi_cnt)
  );

  scl_phase_engine #(
    .FW          (FIELD_W),
    .UNIT_LOG2   (UNIT_LOG2),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (enable),
    .line_hi    (line_hi),
    .lo_cnt     (lo_cnt),
    .hi_cnt     (hi_cnt),
    .load       (load),
    .drive_low  (scl_oe),
    .low_start  (low_start_stb),
    .mid_low    (mid_low_stb),
    .high_start (high_start_stb),
    .mid_high   (mid_high_stb)
  );
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_oe,
  input logic low_start_stb,
  input logic mid_low_stb,
  input logic high_start_stb,
  input logic mid_high_stb
);
  p_park_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_oe && !low_start_stb && !mid_low_stb && !high_start_stb && !mid_high_stb));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start_stb, mid_low_stb, high_start_stb, mid_high_stb}));

  p_low_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> low_start_stb);

  p_high_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && $past(enable)) |-> high_start_stb);

  p_mid_low_placed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low_stb |-> scl_oe);

  p_mid_high_placed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high_stb |-> !scl_oe);

  p_start_on_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !$past(enable) && !scl_oe && !high_start_stb && !mid_high_stb) |=> (enable ? low_start_stb : 1'b1));
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .scl_oe         (scl_oe),
  .low_start_stb  (low_start_stb),
  .mid_low_stb    (mid_low_stb),
  .high_start_stb (high_start_stb),
  .mid_high_stb   (mid_high_stb)
);

// File: tb/sim_scl_phase_gen.sv
`timescale 1ns/1ps
module sim_scl_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [31:0] div_cfg;
  logic        stretch;
  logic        scl_in;
  logic        scl_oe, low_start_stb, mid_low_stb, high_start_stb, mid_high_stb;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  // open-drain line: low when driven or when the target stretches
  assign scl_in = !scl_oe && !stretch;

  scl_phase_gen u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .div_cfg        (div_cfg),
    .scl_in         (scl_in),
    .scl_oe         (scl_oe),
    .low_start_stb  (low_start_stb),
    .mid_low_stb    (mid_low_stb),
    .high_start_stb (high_start_stb),
    .mid_high_stb   (mid_high_stb)
  );

  // {div_cfg, expected low cycles, expected high cycles}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, 16'd8,    16'd8},
    {32'h0000_0001, 16'd16,   16'd8},
    {32'h0003_0000, 16'd8,    16'd32},
    {32'h0005_0002, 16'd24,   16'd48},
    {32'h0001_0010, 16'd136,  16'd16},
    {32'h0000_00FF, 16'd2048, 16'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      summary();
    end
  end

  // Entry: at a negedge that is the first sample of a low phase.
  // Exit: at the negedge that is the first sample of the next low phase.
  task automatic run_period(input int k_stretch,
                            output int lo, output int hi,
                            output int mli, output int mhi,
                            output int mln, output int mhn,
                            output int lsok, output int hsok);
    lo = 0; hi = 0; mli = -1; mhi = -1; mln = 0; mhn = 0;
    lsok = int'(low_start_stb);
    while (scl_oe) begin
      if (mid_low_stb) begin mli = lo; mln++; end
      lo++;
      @(negedge clk);
    end
    hsok = int'(high_start_stb);
    while (!scl_oe) begin
      if (mid_high_stb) begin mhi = hi; mhn++; end
      hi++;
      if (k_stretch > 0 && hi == k_stretch) stretch = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic start_gen(input logic [31:0] d);
    enable = 1'b0;
    div_cfg = d;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk("R9 oe after enable", int'(scl_oe), 1);
    chk("R9 low_start after enable", int'(low_start_stb), 1);
  endtask

  initial begin
    int lo, hi, mli, mhi, mln, mhn, lsok, hsok, strobes;
    rst_n = 1'b0;
    enable = 1'b0;
    div_cfg = '0;
    stretch = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe in reset", int'(scl_oe), 0);
    chk("R1 strobes in reset",
        int'({low_start_stb, mid_low_stb, high_start_stb, mid_high_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      start_gen(VEC[v][63:32]);
      for (int p = 0; p < 2; p++) begin
        run_period(0, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
        chk("R2 low length", lo, int'(VEC[v][31:16]));
        chk("R3 high length", hi, int'(VEC[v][15:0]));
        chk("R4 low_start at first low cycle", lsok, 1);
        chk("R4 high_start at first high cycle", hsok, 1);
        chk("R5 mid_low position", mli, int'(VEC[v][31:16]) / 2);
        chk("R5 mid_low count", mln, 1);
        chk("R6 mid_high position", mhi, int'(VEC[v][15:0]) / 2);
        chk("R6 mid_high count", mhn, 1);
      end
    end

    // R8: change divider after the low phase has begun
    start_gen(32'h0002_0001);
    div_cfg = 32'h0000_0003;
    run_period(0, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
    chk("R8 current low keeps old value", lo, 16);
    chk("R8 current high keeps old value", hi, 24);
    run_period(0, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
    chk("R8 next low uses new value", lo, 32);
    chk("R8 next high uses new value", hi, 8);

    // R7: target stretches SCL for 20 sampled cycles after release
    start_gen(32'h0000_0000);
    stretch = 1'b1;
    run_period(20, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
    chk("R2 low unaffected by line", lo, 8);
    chk("R7 stretched high length", hi, 20 + 8 - 1);
    chk("R7 mid_high once when stretched", mhn, 1);
    run_period(0, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
    chk("R7 next high normal", hi, 8);

    // R1: disable in mid high phase, then observe a parked generator
    start_gen(32'h0003_0000);
    while (scl_oe) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    strobes = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      strobes += int'(scl_oe) + int'(low_start_stb) + int'(mid_low_stb)
               + int'(high_start_stb) + int'(mid_high_stb);
    end
    chk("R1 parked while disabled", strobes, 0);
    // R9: re-enable restarts a fresh low phase
    enable = 1'b1;
    @(negedge clk);
    chk("R9 restart oe", int'(scl_oe), 1);
    chk("R9 restart low_start", int'(low_start_stb), 1);
    run_period(0, lo, hi, mli, mhi, mln, mhn, lsok, hsok);
    chk("R9 restart full low", lo, 8);

    summary();
  end
endmodule